// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block evaluates a configurable two-level logic function. Twenty input signals are each offered to the array in true and in inverted form, which gives forty columns. Sixty-four product-term rows each AND together whichever of those columns their configuration bits select. The OR stage is fixed: consecutive groups of eight rows are ORed into eight sum outputs, and these feed downstream output cells.

The configuration is a 2560-bit fuse vector held in a shift register. Software or a test controller loads it one bit per clock by asserting a load enable and presenting each bit on a serial data pin, most significant bit first. The outputs follow the inputs and the stored fuses with no clock in between. The fuses must be loaded before the outputs are used. While a load is in progress the outputs are not meaningful.

Top module: `sop_array`

## Requirements
- R1: Reset clears every fuse bit to 0, so every row reads HIGH and `sumOut` reads 8'hFF until new fuses are loaded.
- R2: Column 2*i carries input `inVec[i]` and column 2*i+1 carries its complement, for i in 0..19.
- R3: Row r (0..63) is controlled by fuse bits r*40 through r*40+39, with fuse bit r*40+c selecting column c. A fuse bit of 1 connects that column. The row is the AND of its connected columns.
- R4: A row with none of its 40 fuse bits set reads HIGH.
- R5: A row that connects both column 2*i and column 2*i+1 for any input i reads LOW for every input value.
- R6: While `loadEn` is high, each clock shifts `shiftIn` into fuse bit 0 and moves every other fuse bit up by one position. The first of 2560 bits shifted therefore ends in fuse bit 2559. A bit sampled at one edge reaches the fuse register at the next edge, so the outputs reflect a finished load two edges after the last bit is presented.
- R7: While `loadEn` is low, the stored fuses do not change, whatever `shiftIn` does.
- R8: `sumOut[k]` is the OR of rows 8*k through 8*k+7.
- R9: `sumOut` follows a change of `inVec` within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for fuse loading |
| rst | input | 1 | Synchronous active-high reset, clears the fuses |
| loadEn | input | 1 | Shift one fuse bit in per clock while high |
| shiftIn | input | 1 | Serial fuse data, most significant bit first |
| inVec | input | 20 | Array input signals |
| sumOut | output | 8 | Sum-of-products outputs, one per group of eight rows |

## Verification
The assertions assume that reset is applied before any load. They also assume that `loadEn` and `shiftIn` are two-state and that the outputs are only used once a load has finished. The row checks rely on the stored fuses being defined, and this holds from reset onward. The bench drives every control input at the falling edge. After the last fuse bit it drops `loadEn` and waits two full cycles before it compares outputs. While it tests the hold behaviour it toggles `shiftIn` only with `loadEn` low.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned SOP_NUM_IN   = 20;
  localparam int unsigned SOP_NUM_SUM  = 8;
  localparam int unsigned SOP_TERM_GRP = 8;

  // strobes from the load control to the fuse datapath
  typedef struct packed {
    logic shift;
    logic bitVal;
  } loadStrb_t;
endpackage

// File: rtl/sop_term.sv
module sop_term #(
  parameter int unsigned NCOL = 40
) (
  input  logic [NCOL-1:0] colVal,
  input  logic [NCOL-1:0] rowFuse,
  output logic            term
);
  // unconnected columns are forced high, so an empty row reads 1
  assign term = &(colVal | ~rowFuse);
endmodule

// File: rtl/sop_load_ctrl.sv
module sop_load_ctrl
  import sop_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      loadEn,
  input  logic      shiftIn,
  output loadStrb_t strb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= '0;
    end else begin
      strb.shift  <= loadEn;
      strb.bitVal <= shiftIn;
    end
  end

  // R6: a sampled load request becomes a shift strobe carrying the sampled bit
  a_r6_strobe_follows_load: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (strb.shift && strb.bitVal == $past(shiftIn)));
  // R7: no load request, no shift strobe
  a_r7_no_strobe_when_idle: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> !strb.shift);
endmodule

// File: rtl/sop_datapath.sv
module sop_datapath
  import sop_pkg::*;
#(
  parameter int unsigned NIN  = SOP_NUM_IN,
  parameter int unsigned NSUM = SOP_NUM_SUM,
  parameter int unsigned NGRP = SOP_TERM_GRP
) (
  input  logic            clk,
  input  logic            rst,
  input  loadStrb_t       strb,
  input  logic [NIN-1:0]  inVec,
  output logic [NSUM-1:0] sumOut
);
  localparam int unsigned NCOL  = 2 * NIN;
  localparam int unsigned NROW  = NSUM * NGRP;
  localparam int unsigned NFUSE = NROW * NCOL;

  logic [NFUSE-1:0] fuse;
  logic [NCOL-1:0]  colVal;
  logic [NROW-1:0]  rowTerm;
  logic [NROW-1:0]  pairHit;
  logic [NROW-1:0]  emptyRow;

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse <= '0;
    end else if (strb.shift) begin
      fuse <= {fuse[NFUSE-2:0], strb.bitVal};
    end
  end

  // true / complement input buffers
  for (genvar i = 0; i < NIN; i++) begin : g_col
    assign colVal[2*i]   = inVec[i];
    assign colVal[2*i+1] = ~inVec[i];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic [NIN-1:0] trueSel;
    logic [NIN-1:0] compSel;
    sop_term #(.NCOL(NCOL)) u_term (
      .colVal (colVal),
      .rowFuse(fuse[r*NCOL +: NCOL]),
      .term   (rowTerm[r])
    );
    for (genvar i = 0; i < NIN; i++) begin : g_pol
      assign trueSel[i] = fuse[r*NCOL + 2*i];
      assign compSel[i] = fuse[r*NCOL + 2*i + 1];
    end
    assign pairHit[r]  = |(trueSel & compSel);
    assign emptyRow[r] = ~|fuse[r*NCOL +: NCOL];
  end

  // fixed OR plane
  for (genvar k = 0; k < NSUM; k++) begin : g_sum
    assign sumOut[k] = |rowTerm[k*NGRP +: NGRP];
  end

  // R4: a row with nothing connected evaluates high
  a_r4_empty_row_high: assert property (@(posedge clk) disable iff (rst)
    (emptyRow & ~rowTerm) == '0);
  // R5: a row holding both polarities of one input evaluates low
  a_r5_pair_row_low: assert property (@(posedge clk) disable iff (rst)
    (pairHit & rowTerm) == '0);
  // R7: fuses hold without a shift strobe
  a_r7_fuse_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.shift |=> $stable(fuse));
  // R9: stable inputs and fuses give stable sums
  a_r9_sum_stable: assert property (@(posedge clk) disable iff (rst)
    ($stable(inVec) && $stable(fuse)) |-> $stable(sumOut));
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int unsigned NIN  = SOP_NUM_IN,
  parameter int unsigned NSUM = SOP_NUM_SUM,
  parameter int unsigned NGRP = SOP_TERM_GRP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            loadEn,
  input  logic            shiftIn,
  input  logic [NIN-1:0]  inVec,
  output logic [NSUM-1:0] sumOut
);
  loadStrb_t strb;

  sop_load_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .loadEn (loadEn),
    .shiftIn(shiftIn),
    .strb   (strb)
  );

  sop_datapath #(.NIN(NIN), .NSUM(NSUM), .NGRP(NGRP)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .inVec (inVec),
    .sumOut(sumOut)
  );
endmodule

// File: tb/sim_sop_array.sv
`timescale 1ns/1ps
module sim_sop_array;
  localparam int NIN = 20;
  localparam int NCOL = 40;
  localparam int NROW = 64;
  localparam int FB = NROW * NCOL;

  typedef struct packed {
    logic [31:0] seed;
    logic [7:0]  den;
  } vecRow_t;

  localparam vecRow_t VEC_TAB [4] = '{
    '{seed: 32'h1234_5678, den: 8'd40},
    '{seed: 32'hCAFE_0001, den: 8'd20},
    '{seed: 32'h0BAD_F00D, den: 8'd80},
    '{seed: 32'h7777_1357, den: 8'd12}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadEn = 1'b0;
  logic shiftIn = 1'b0;
  logic [NIN-1:0] inVec = '0;
  logic [7:0] sumOut;
  int nChk = 0;
  int nFail = 0;
  logic [31:0] rng;

  always #2.5 clk = ~clk;

  sop_array u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .shiftIn(shiftIn),
    .inVec(inVec), .sumOut(sumOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  function automatic logic [7:0] model(input logic [FB-1:0] f, input logic [NIN-1:0] x);
    logic [7:0] s;
    s = '0;
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < 8; t++) begin
        logic term;
        term = 1'b1;
        for (int c = 0; c < NCOL; c++) begin
          logic cv;
          cv = (c % 2 == 1) ? ~x[c/2] : x[c/2];
          if (f[(k*8+t)*NCOL + c] && !cv) term = 1'b0;
        end
        s[k] = s[k] | term;
      end
    end
    return s;
  endfunction

  task automatic loadFuses(input logic [FB-1:0] f);
    for (int i = FB - 1; i >= 0; i--) begin
      @(negedge clk);
      loadEn = 1'b1;
      shiftIn = f[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    shiftIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [FB-1:0] f;
    logic [7:0] exp;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: cleared fuses, every row high
    chk("R1 reset", sumOut, 8'hFF);
    inVec = 20'hA5A5A;
    #1 chk("R1 reset any input", sumOut, 8'hFF);

    // table-driven random patterns against the software model (R3, R6, R8)
    for (int e = 0; e < 4; e++) begin
      rng = VEC_TAB[e].seed;
      for (int b = 0; b < FB; b++) begin
        rng = xs(rng);
        f[b] = ((rng % VEC_TAB[e].den) == 0);
      end
      loadFuses(f);
      for (int v = 0; v < 16; v++) begin
        rng = xs(rng);
        inVec = rng[NIN-1:0];
        #1 chk("R8 random sum-of-products", sumOut, model(f, inVec));
        @(negedge clk);
      end
    end

    // directed pattern: R2, R3, R4, R5, R6 bit order
    f = '0;
    for (int r = 0; r < NROW; r++) begin
      if (r != 0 && r != 8 && r != 24 && !(r >= 16 && r < 24)) begin
        f[r*NCOL + 0] = 1'b1;
        f[r*NCOL + 1] = 1'b1;
      end
    end
    f[0*NCOL + 0]  = 1'b1;  // row 0: in0 true
    f[8*NCOL + 7]  = 1'b1;  // row 8: in3 complement
    f[24*NCOL + 2] = 1'b1;  // row 24: in1 true
    f[24*NCOL + 39] = 1'b1; // row 24: in19 complement
    loadFuses(f);
    for (int v = 0; v < 6; v++) begin
      logic [NIN-1:0] x;
      case (v)
        0: x = 20'h00000;
        1: x = 20'h00001;
        2: x = 20'h00008;
        3: x = 20'h00002;
        4: x = 20'h80002;
        default: x = 20'hFFFFF;
      endcase
      inVec = x;
      exp = {4'b0000, x[1] & ~x[19], 1'b1, ~x[3], x[0]};
      // R9: checked 1 ns after the input change, no clock edge between
      #1 chk("R2 R3 R4 R5 R9 directed", sumOut, exp);
      @(negedge clk);
    end

    // R7: toggling serial data with load disabled changes nothing
    inVec = 20'h00009;
    #1 held = sumOut;
    chk("R7 before toggle", held, 8'b0000_0101);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      shiftIn = ~shiftIn;
    end
    repeat (2) @(negedge clk);
    chk("R7 hold after toggle", sumOut, held);
    shiftIn = 1'b0;

    // R6: one extra bit shifts every fuse up by one; row 0 bit 0 moves to column 1
    @(negedge clk);
    loadEn = 1'b1;
    shiftIn = 1'b0;
    @(negedge clk);
    loadEn = 1'b0;
    repeat (2) @(negedge clk);
    inVec = 20'h00000;
    // row 0 now holds column 1 only (~in0); sum0 rows 1..7 shifted to cols 1,2 -> ~in0 & in1
    #1 chk("R6 shift by one in0=0", sumOut[0], 1'b1);
    inVec = 20'h00001;
    #1 chk("R6 shift by one in0=1", sumOut[0], 1'b0);

    // R1: reset after a load clears all fuses
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset after load", sumOut, 8'hFF);

    finishRun();
  end
endmodule